// File: doc/BRIEF.md
# Drive-Cycle Locked Frame Scheduler

This block decides when each serial link frame begins. Without an external reference it emits a frame start strobe at a fixed period, counted in ticks of the nominal bit clock. The default is 122 bit times, about 13 µs. When the drive controller supplies a periodic sync signal, the block measures the sync period in system-clock cycles. It then places a programmed number of frame starts into every sync period. The spacing is the integer quotient of the period and the frame count, and the final frame absorbs the remainder.

Each sync edge is compared with the time at which it is expected: the previous edge plus the measured period. An edge that deviates by more than the tolerance clears the lock flag. The tolerance is 26 ns, converted to whole clock cycles. Scheduling nevertheless stays synchronized, so a single disturbed edge costs only the flag. Edges that stay wrong, or stop arriving, count against a limit of consecutive failures. A missing edge is detected by a timeout at 1.5 times the measured period. Once the limit is reached, the scheduler returns to the fixed period. Lock is granted again after four consecutive good edges.

Top module: `sync_frame_sched`

## Requirements
- R1: During and right after reset, `sync_locked` is 0, the block is in fixed-period mode and `frame_strobe` is 0.
- R2: In fixed-period mode a one-cycle `frame_strobe` appears once every FREE_BITS cycles in which `bit_tick` is 1. Cycles with `bit_tick` at 0 do not advance the count.
- R3: The first sync edge sets the reference. The second edge measures the period. Every later edge is judged against that period. Four consecutive good edges switch the block to synchronized mode and raise `sync_locked`. The flag becomes visible two clock cycles after the edge is first sampled high.
- R4: In synchronized mode every sync edge starts a burst of N strobes, N being `frames_per_cycle`. The first strobe is visible two cycles after the edge is sampled, and the strobes are spaced floor(P/N) cycles apart. No further strobe appears until the next edge, so the last frame receives the remainder.
- R5: A `frames_per_cycle` value of 0 behaves as 1: one strobe per sync edge.
- R6: An edge is good when its distance from the expected time is at most floor(SYNC_TOL_PS / CLK_PERIOD_PS) cycles, which is 6 at the defaults. The expected time is the previous edge plus the period. The period is remeasured only in fixed-period mode and is held while synchronized.
- R7: A bad edge clears `sync_locked` at the same point where a good edge would set it. Synchronized bursts continue on later edges while fewer than MISS_LIMIT consecutive bad events have occurred.
- R8: After a loss, `sync_locked` returns on the fourth consecutive good edge.
- R9: No edge within 1.5·P cycles after the last edge counts as one bad event, and every further P cycles without an edge counts as another. MISS_LIMIT consecutive bad events (3 by default) return the block to fixed-period strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | External drive-cycle sync; its rising edge marks a cycle start |
| frames_per_cycle | input | FW (4) | Frames per sync period (0 behaves as 1) |
| bit_tick | input | 1 | One-cycle pulse per nominal link bit time |
| frame_strobe | output | 1 | One-cycle frame start pulse |
| sync_locked | output | 1 | 1 while sync edges arrive within tolerance |

## Verification
A wrong period register or expected-edge reference appears as a misplaced burst strobe, or a wrongly set lock flag, at the first sync edge after the fault. The bench compares every burst strobe to the cycle. A corrupted good or bad streak counter shows up as the lock flag rising on the third or fifth good edge instead of the fourth. It can also show up as a fallback to fixed-period strobes one timeout early or late. The bench checks these at the exact edge or timeout where they decide. A broken fixed-period counter changes the strobe spacing within one period.

// File: rtl/fs_sched_pkg.sv
package fs_sched_pkg;

    typedef enum logic {
        SCHED_FREE = 1'b0,
        SCHED_SYNC = 1'b1
    } sched_mode_e;

    typedef struct packed {
        logic good;
        logic bad;
    } edge_verdict_t;

    function automatic logic [31:0] abs_diff(input logic [31:0] a, input logic [31:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/fs_sync_edge.sv
module fs_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic edge_p
);
    logic s_q1;
    logic s_q2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q1 <= 1'b0;
            s_q2 <= 1'b0;
        end else begin
            s_q1 <= sync_in;
            s_q2 <= s_q1;
        end
    end

    assign edge_p = s_q1 & ~s_q2;
endmodule

// File: rtl/fs_edge_timer.sv
module fs_edge_timer
    import fs_sched_pkg::*;
#(
    parameter int PER_W   = 20,
    parameter int TOL_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_p,
    input  logic             sync_mode,
    output logic [PER_W-1:0] per_q,
    output edge_verdict_t    verdict
);
    localparam logic [PER_W-1:0] ELAPSED_MAX = '1;

    logic [PER_W-1:0] elapsed;
    logic             have_ref;
    logic             have_per;
    logic [PER_W:0]   tmo_lim;
    logic [31:0]      err;
    logic             in_tol;
    logic             timeout;

    assign tmo_lim = {1'b0, per_q} + {2'b00, per_q[PER_W-1:1]};
    assign err     = abs_diff(32'(elapsed), 32'(per_q));
    assign in_tol  = (err <= 32'(TOL_CYC));
    assign timeout = have_per && !edge_p && ({1'b0, elapsed} >= tmo_lim);

    assign verdict.good = edge_p && have_per && in_tol;
    assign verdict.bad  = (edge_p && have_per && !in_tol) || timeout;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed  <= '0;
            per_q    <= '0;
            have_ref <= 1'b0;
            have_per <= 1'b0;
        end else if (edge_p) begin
            elapsed  <= PER_W'(1);
            have_ref <= 1'b1;
            if (have_ref && (!have_per || !sync_mode)) begin
                per_q    <= elapsed;
                have_per <= 1'b1;
            end
        end else if (timeout) begin
            elapsed <= {1'b0, per_q[PER_W-1:1]} + PER_W'(1);
        end else if (elapsed != ELAPSED_MAX) begin
            elapsed <= elapsed + PER_W'(1);
        end
    end

    // R6
    per_held_chk: assert property (@(posedge clk) disable iff (rst)
        sync_mode |=> per_q == $past(per_q));

    // R9
    verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(verdict.good && verdict.bad));
endmodule

// File: rtl/fs_lock_ctrl.sv
module fs_lock_ctrl
    import fs_sched_pkg::*;
#(
    parameter int MISS_LIMIT = 3,
    parameter int LOCK_GOOD  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_verdict_t verdict,
    output sched_mode_e   mode,
    output logic          locked
);
    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int BW = $clog2(MISS_LIMIT + 1);

    logic [GW-1:0] good_run;
    logic [BW-1:0] bad_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= SCHED_FREE;
            locked   <= 1'b0;
            good_run <= '0;
            bad_run  <= '0;
        end else if (verdict.good) begin
            bad_run <= '0;
            if (good_run != GW'(LOCK_GOOD)) good_run <= good_run + GW'(1);
            if (good_run >= GW'(LOCK_GOOD - 1)) begin
                locked <= 1'b1;
                mode   <= SCHED_SYNC;
            end
        end else if (verdict.bad) begin
            good_run <= '0;
            locked   <= 1'b0;
            if (bad_run >= BW'(MISS_LIMIT - 1)) begin
                bad_run <= '0;
                mode    <= SCHED_FREE;
            end else begin
                bad_run <= bad_run + BW'(1);
            end
        end
    end

    // R7
    bad_clears_lock_chk: assert property (@(posedge clk) disable iff (rst)
        verdict.bad |=> !locked);

    // R3
    lock_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        locked |-> mode == SCHED_SYNC);

    // R8
    lock_rise_on_good_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(verdict.good));
endmodule

// File: rtl/fs_frame_gen.sv
module fs_frame_gen
    import fs_sched_pkg::*;
#(
    parameter int PER_W     = 20,
    parameter int FW        = 4,
    parameter int FREE_BITS = 122
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_p,
    input  sched_mode_e      mode,
    input  logic [PER_W-1:0] per_q,
    input  logic [FW-1:0]    frames_per_cycle,
    input  logic             bit_tick,
    output logic             frame_strobe
);
    localparam int FT_W = $clog2(FREE_BITS + 1);

    logic [FW-1:0]    n_eff;
    logic [PER_W-1:0] ivl_raw;
    logic [PER_W-1:0] ivl;
    logic             active;
    logic [FW-1:0]    issued;
    logic [FW-1:0]    n_lat;
    logic [PER_W-1:0] tmr;
    logic [PER_W-1:0] ivl_q;
    logic [FT_W-1:0]  ftmr;

    assign n_eff   = (frames_per_cycle == '0) ? FW'(1) : frames_per_cycle;
    assign ivl_raw = per_q / PER_W'(n_eff);
    assign ivl     = (ivl_raw == '0) ? PER_W'(1) : ivl_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_strobe <= 1'b0;
            active       <= 1'b0;
            issued       <= '0;
            n_lat        <= '0;
            tmr          <= '0;
            ivl_q        <= '0;
            ftmr         <= '0;
        end else begin
            frame_strobe <= 1'b0;
            if (mode == SCHED_SYNC) begin
                ftmr <= '0;
                if (edge_p) begin
                    frame_strobe <= 1'b1;
                    issued       <= FW'(1);
                    n_lat        <= n_eff;
                    ivl_q        <= ivl;
                    tmr          <= ivl - PER_W'(1);
                    active       <= (n_eff != FW'(1));
                end else if (active) begin
                    if (tmr == '0) begin
                        frame_strobe <= 1'b1;
                        tmr          <= ivl_q - PER_W'(1);
                        issued       <= issued + FW'(1);
                        if (issued + FW'(1) == n_lat) active <= 1'b0;
                    end else begin
                        tmr <= tmr - PER_W'(1);
                    end
                end
            end else begin
                active <= 1'b0;
                if (bit_tick) begin
                    if (ftmr == FT_W'(FREE_BITS - 1)) begin
                        frame_strobe <= 1'b1;
                        ftmr         <= '0;
                    end else begin
                        ftmr <= ftmr + FT_W'(1);
                    end
                end
            end
        end
    end

    // R4
    no_stray_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SCHED_SYNC && !edge_p && !active) |=> !frame_strobe);

    // R2
    free_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SCHED_FREE && !bit_tick) |=> !frame_strobe);
endmodule

// File: rtl/sync_frame_sched.sv
module sync_frame_sched
    import fs_sched_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int SYNC_TOL_PS   = 26000,
    parameter int FREE_BITS     = 122,
    parameter int MISS_LIMIT    = 3,
    parameter int LOCK_GOOD     = 4,
    parameter int PER_W         = 20,
    parameter int FW            = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_in,
    input  logic [FW-1:0] frames_per_cycle,
    input  logic          bit_tick,
    output logic          frame_strobe,
    output logic          sync_locked
);
    localparam int TOL_CYC = SYNC_TOL_PS / CLK_PERIOD_PS;

    logic             edge_p;
    logic [PER_W-1:0] per_q;
    edge_verdict_t    verdict;
    sched_mode_e      mode;

    fs_sync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .edge_p  (edge_p)
    );

    fs_edge_timer #(.PER_W(PER_W), .TOL_CYC(TOL_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .edge_p    (edge_p),
        .sync_mode (mode == SCHED_SYNC),
        .per_q     (per_q),
        .verdict   (verdict)
    );

    fs_lock_ctrl #(.MISS_LIMIT(MISS_LIMIT), .LOCK_GOOD(LOCK_GOOD)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .verdict (verdict),
        .mode    (mode),
        .locked  (sync_locked)
    );

    fs_frame_gen #(.PER_W(PER_W), .FW(FW), .FREE_BITS(FREE_BITS)) u_gen (
        .clk              (clk),
        .rst              (rst),
        .edge_p           (edge_p),
        .mode             (mode),
        .per_q            (per_q),
        .frames_per_cycle (frames_per_cycle),
        .bit_tick         (bit_tick),
        .frame_strobe     (frame_strobe)
    );

    // R1
    reset_unlocked_chk: assert property (@(posedge clk)
        $past(rst) |-> !sync_locked && !frame_strobe);
endmodule

// File: tb/sync_frame_sched_tb.sv
module sync_frame_sched_tb;
    localparam int FREE_BITS = 50;
    localparam int SYNC_P    = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic [3:0] frames_per_cycle = 4'd3;
    logic       bit_tick = 1'b1;
    logic       tick_half = 1'b0;
    logic       frame_strobe;
    logic       sync_locked;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    int got_q[$];
    int exp_q[$];

    sync_frame_sched #(.FREE_BITS(FREE_BITS)) u_dut (
        .clk              (clk),
        .rst              (rst),
        .sync_in          (sync_in),
        .frames_per_cycle (frames_per_cycle),
        .bit_tick         (bit_tick),
        .frame_strobe     (frame_strobe),
        .sync_locked      (sync_locked)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tick_half) bit_tick <= ~bit_tick;
        else           bit_tick <= 1'b1;
    end

    // monitor: record every strobe cycle
    always @(negedge clk) begin
        if (!rst && frame_strobe) got_q.push_back(cyc);
    end

    task automatic check_val(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // driver: raise sync at cycle k, push the expected burst strobes
    task automatic drive_edge(input int k, input int n_exp);
        wait_cyc(k);
        sync_in = 1'b1;
        for (int i = 0; i < n_exp; i++) exp_q.push_back(k + 2 + i * (SYNC_P / n_exp));
        wait_cyc(k + 2);
        sync_in = 1'b0;
    endtask

    task automatic compare_sb(input string req);
        while (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            if (got_q.size() == 0) check_val(req, -1, e);
            else                   check_val(req, got_q.pop_front(), e);
        end
        if (got_q.size() != 0) check_val(req, got_q.size(), 0);
        got_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        wait_cyc(3);
        check_val("R1 lock in reset", int'(sync_locked), 0);
        check_val("R1 strobe in reset", int'(frame_strobe), 0);
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(8);
        check_val("R1 lock after reset", int'(sync_locked), 0);
        check_val("R1 strobe after reset", int'(frame_strobe), 0);

        // R2 fixed period, tick every cycle
        wait_cyc(10);
        got_q.delete();
        wait_cyc(250);
        check_val("R2 enough strobes", int'(got_q.size() >= 3), 1);
        if (got_q.size() >= 3) check_val("R2 spacing full tick", got_q[2] - got_q[1], FREE_BITS);

        // R2 tick every other cycle
        tick_half = 1'b1;
        wait_cyc(260);
        got_q.delete();
        wait_cyc(620);
        check_val("R2 enough strobes half", int'(got_q.size() >= 3), 1);
        if (got_q.size() >= 3) check_val("R2 spacing half tick", got_q[2] - got_q[1], 2 * FREE_BITS);
        tick_half = 1'b0;

        // R3 acquisition: six nominal edges
        for (int j = 0; j < 5; j++) drive_edge(800 + j * SYNC_P, 0);
        check_val("R3 no lock after third good", int'(sync_locked), 0);
        drive_edge(800 + 5 * SYNC_P, 0);
        check_val("R3 lock after fourth good", int'(sync_locked), 1);
        @(negedge clk);
        got_q.delete();
        exp_q.delete();

        // R4 bursts of three
        drive_edge(1280, 3);
        drive_edge(1360, 3);
        drive_edge(1440, 3);
        wait_cyc(1510);
        compare_sb("R4");

        // R6 tolerance boundary: late by 6 is good
        drive_edge(1526, 3);
        check_val("R6 edge at tolerance keeps lock", int'(sync_locked), 1);
        drive_edge(1600, 3);
        check_val("R6 return to grid keeps lock", int'(sync_locked), 1);
        // R7 late by 7 is bad, sync retained
        drive_edge(1687, 3);
        check_val("R7 bad edge clears lock", int'(sync_locked), 0);
        drive_edge(1760, 3);
        check_val("R7 second bad edge lock low", int'(sync_locked), 0);
        // R8 four good edges
        drive_edge(1840, 3);
        drive_edge(1920, 3);
        drive_edge(2000, 3);
        check_val("R8 no lock after three good", int'(sync_locked), 0);
        drive_edge(2080, 3);
        check_val("R8 lock after four good", int'(sync_locked), 1);
        wait_cyc(2150);
        compare_sb("R7 bursts kept");

        // R5 zero frames behaves as one
        frames_per_cycle = 4'd0;
        drive_edge(2160, 1);
        drive_edge(2240, 1);
        wait_cyc(2310);
        compare_sb("R5");

        // R4 two frames per cycle
        frames_per_cycle = 4'd2;
        drive_edge(2320, 2);
        wait_cyc(2390);
        compare_sb("R4 two frames");

        // R9 edges stop
        wait_cyc(2470);
        check_val("R9 timeout clears lock", int'(sync_locked), 0);
        wait_cyc(2590);
        check_val("R9 no fallback before limit", got_q.size(), 0);
        wait_cyc(2900);
        check_val("R9 fallback strobes", int'(got_q.size() >= 3), 1);
        if (got_q.size() >= 3) check_val("R9 fallback spacing", got_q[2] - got_q[1], FREE_BITS);
        check_val("R9 lock stays low", int'(sync_locked), 0);

        summary();
        $finish;
    end
endmodule